// File: doc/BRIEF.md
# Object pointer validity checker

This block answers one question in hardware: does a 64-bit value name a live heap object? A request carries the candidate value. The block first applies a mask test that looks at the value alone. That test requires a 32-byte-aligned address that lies inside an 8 MB window starting at zero.

Only a value that passes the mask test goes on to memory. For such a value the block issues one read of the word 24 bytes above the candidate address. It then compares that word against the object signature 0x4F424A, which is the letters O, B and J packed with O in the top byte.

The answer is 1 only when both tests succeed. It is reported with a one-cycle done pulse. A value that fails the mask test never causes a memory access, so a garbage value cannot reach I/O space or unmapped pages. A collector's inner loop can use the block in place of a branching test-and-load sequence. The read port is a plain request/response pair that accepts any response latency.

Top module: `objptr_probe`

## Requirements
- R1: After reset, `done` and `mem_rd_req` are 0 and `req_ready` is 1.
- R2: A candidate with any of bits [4:0] set yields `is_obj`=0, and no read is issued for it.
- R3: A candidate with any of bits [63:23] set yields `is_obj`=0, and no read is issued for it. 0x7FFFE0 is the highest address that passes.
- R4: A candidate that passes the mask test causes exactly one read, at address candidate+24.
- R5: If the word returned by that read equals 0x4F424A (full 64-bit compare, upper bits zero) and carries no error flag, then `is_obj`=1.
- R6: A returned word that differs from 0x4F424A in any bit, including bits above bit 23, yields `is_obj`=0.
- R7: A read response with `mem_rd_rsp_err`=1 yields `is_obj`=0, even when its data matches the signature.
- R8: Each accepted request produces exactly one `done` pulse, one cycle wide, with `is_obj` valid in that cycle.
- R9: Requests are accepted only while `req_ready`=1 (idle). A `req_valid` asserted while the block is busy is ignored: it causes no read and no extra `done`.
- R10: `mem_rd_req` is high for a single cycle per read. The response may arrive in any later cycle, from the cycle that `mem_rd_req` is high onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is high |
| req_value | input | 64 | Candidate pointer value |
| req_ready | output | 1 | High while idle |
| done | output | 1 | One-cycle completion pulse |
| is_obj | output | 1 | Result, valid with `done` |
| mem_rd_req | output | 1 | One-cycle read request |
| mem_rd_addr | output | 64 | Read address (candidate + 24) |
| mem_rd_rsp_valid | input | 1 | Read response strobe |
| mem_rd_rsp_data | input | 64 | Read response word |
| mem_rd_rsp_err | input | 1 | Read response error flag |

## Verification
The hardest situation to reach from the ports is a new `req_valid` that arrives while a read is still outstanding. This strobe must leave no trace. To reach it, the stimulus holds back the memory response for many cycles and pulses a request with a valid-looking candidate into that window. It then confirms that the number of reads and the number of `done` pulses match only the original request. Zero-latency and long-latency responses, an error response carrying a matching word, and candidates sitting exactly on the mask boundaries cover the remaining corners.

// File: rtl/objptr_pkg.sv
package objptr_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_MASK  = 3'd1,
      ST_WAIT  = 3'd2,
      ST_CMP   = 3'd3,
      ST_DONE  = 3'd4
   } probe_state_t;
endpackage

// File: rtl/objptr_mask_test.sv
// Pure value test: alignment and range, plus the probe address.
module objptr_mask_test #(
   parameter int          DATA_W     = 64,
   parameter int          ALIGN_BITS = 5,
   parameter int          RANGE_BITS = 23,
   parameter logic [63:0] TAG_OFFSET = 64'd24
) (
   input  logic [DATA_W-1:0] cand,
   output logic              mask_ok,
   output logic [DATA_W-1:0] probe_addr
);
   localparam int HIGH_W = DATA_W - RANGE_BITS;

   initial begin
      assert (ALIGN_BITS > 0 && ALIGN_BITS < RANGE_BITS)
         else $error("objptr_mask_test: ALIGN_BITS out of range");
      assert (RANGE_BITS < DATA_W)
         else $error("objptr_mask_test: RANGE_BITS must be below DATA_W");
   end

   logic low_clear;
   logic high_clear;

   always_comb begin
      low_clear  = (cand[ALIGN_BITS-1:0] == '0);
      high_clear = (cand[DATA_W-1:RANGE_BITS] == {HIGH_W{1'b0}});
      mask_ok    = low_clear && high_clear;
      probe_addr = cand + TAG_OFFSET[DATA_W-1:0];
   end
endmodule

// File: rtl/objptr_sig_match.sv
// Signature comparison; the variant picks full-word or low-field compare.
module objptr_sig_match #(
   parameter int          DATA_W     = 64,
   parameter logic [63:0] SIGNATURE  = 64'h4F424A,
   parameter bit          FULL_WORD  = 1'b1,
   parameter int          SIG_W      = 24
) (
   input  logic [DATA_W-1:0] word,
   output logic              hit
);
   initial begin
      assert (SIG_W > 0 && SIG_W <= DATA_W)
         else $error("objptr_sig_match: SIG_W out of range");
   end

   generate
      if (FULL_WORD) begin : g_full
         always_comb hit = (word == SIGNATURE[DATA_W-1:0]);
      end else begin : g_field
         always_comb hit = (word[SIG_W-1:0] == SIGNATURE[SIG_W-1:0]);
      end
   endgenerate
endmodule

// File: rtl/objptr_seq.sv
// Sequencer: idle, mask check, read wait, compare, done.
module objptr_seq
   import objptr_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [DATA_W-1:0] req_value,
   input  logic              mask_ok,
   input  logic              sig_hit,
   input  logic              rsp_valid,
   input  logic [DATA_W-1:0] rsp_data,
   input  logic              rsp_err,
   output logic [DATA_W-1:0] cand_q,
   output logic [DATA_W-1:0] word_q,
   output logic              rd_req,
   output logic              ready,
   output logic              done,
   output logic              result
);
   probe_state_t st;
   logic         err_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         cand_q <= '0;
         word_q <= '0;
         err_q  <= 1'b0;
         rd_req <= 1'b0;
         result <= 1'b0;
      end else begin
         case (st)
            ST_IDLE: begin
               if (req_valid) begin
                  cand_q <= req_value;
                  st     <= ST_MASK;
               end
            end
            ST_MASK: begin
               if (mask_ok) begin
                  rd_req <= 1'b1;
                  st     <= ST_WAIT;
               end else begin
                  result <= 1'b0;
                  st     <= ST_DONE;
               end
            end
            ST_WAIT: begin
               rd_req <= 1'b0;
               if (rsp_valid) begin
                  word_q <= rsp_data;
                  err_q  <= rsp_err;
                  st     <= ST_CMP;
               end
            end
            ST_CMP: begin
               result <= sig_hit && !err_q;
               st     <= ST_DONE;
            end
            ST_DONE: st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      ready = (st == ST_IDLE);
      done  = (st == ST_DONE);
   end

   // An error response never produces a positive answer.
   p_err_forces_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_CMP && err_q) |=> (done && !result));

   // Busy states never accept a new candidate.
   p_busy_holds_cand_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (st != ST_IDLE && $past(st) != ST_IDLE) |-> $stable(cand_q));
endmodule

// File: rtl/objptr_probe.sv
module objptr_probe #(
   parameter int          DATA_W     = 64,
   parameter int          ALIGN_BITS = 5,
   parameter int          RANGE_BITS = 23,
   parameter logic [63:0] TAG_OFFSET = 64'd24,
   parameter logic [63:0] SIGNATURE  = 64'h4F424A,
   parameter bit          FULL_WORD  = 1'b1,
   parameter int          SIG_W      = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [DATA_W-1:0] req_value,
   output logic              req_ready,
   output logic              done,
   output logic              is_obj,
   output logic              mem_rd_req,
   output logic [DATA_W-1:0] mem_rd_addr,
   input  logic              mem_rd_rsp_valid,
   input  logic [DATA_W-1:0] mem_rd_rsp_data,
   input  logic              mem_rd_rsp_err
);
   initial begin
      assert (DATA_W >= 32 && DATA_W <= 64)
         else $error("objptr_probe: DATA_W must be 32..64");
   end

   logic [DATA_W-1:0] cand_q;
   logic [DATA_W-1:0] word_q;
   logic              mask_ok;
   logic              sig_hit;

   objptr_mask_test #(
      .DATA_W(DATA_W), .ALIGN_BITS(ALIGN_BITS),
      .RANGE_BITS(RANGE_BITS), .TAG_OFFSET(TAG_OFFSET)
   ) u_mask (
      .cand(cand_q), .mask_ok(mask_ok), .probe_addr(mem_rd_addr)
   );

   objptr_sig_match #(
      .DATA_W(DATA_W), .SIGNATURE(SIGNATURE),
      .FULL_WORD(FULL_WORD), .SIG_W(SIG_W)
   ) u_match (
      .word(word_q), .hit(sig_hit)
   );

   objptr_seq #(.DATA_W(DATA_W)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_value(req_value),
      .mask_ok(mask_ok), .sig_hit(sig_hit),
      .rsp_valid(mem_rd_rsp_valid), .rsp_data(mem_rd_rsp_data),
      .rsp_err(mem_rd_rsp_err),
      .cand_q(cand_q), .word_q(word_q),
      .rd_req(mem_rd_req), .ready(req_ready),
      .done(done), .result(is_obj)
   );

   // A read only ever goes out for a candidate that passed the mask.
   p_no_read_bad_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_req |-> (cand_q[ALIGN_BITS-1:0] == '0));
   p_no_read_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_req |-> (cand_q[DATA_W-1:RANGE_BITS] == '0));
   // The probe address keeps the signature offset in its low bits.
   p_probe_offset_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_req |-> (mem_rd_addr[ALIGN_BITS-1:0] == TAG_OFFSET[ALIGN_BITS-1:0]));
   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && req_ready));
   p_req_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_req |=> !mem_rd_req);
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (!mem_rd_req && !done));
endmodule

// File: tb/sim_objptr_probe.sv
module sim_objptr_probe;
   localparam logic [63:0] MAGIC = 64'h4F424A;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [63:0] req_value = '0;
   logic        req_ready, done, is_obj, mem_rd_req;
   logic [63:0] mem_rd_addr;
   logic        mem_rd_rsp_valid = 1'b0;
   logic [63:0] mem_rd_rsp_data = '0;
   logic        mem_rd_rsp_err = 1'b0;

   always #5 clk = ~clk;

   objptr_probe u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_value(req_value),
      .req_ready(req_ready), .done(done), .is_obj(is_obj),
      .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
      .mem_rd_rsp_valid(mem_rd_rsp_valid), .mem_rd_rsp_data(mem_rd_rsp_data),
      .mem_rd_rsp_err(mem_rd_rsp_err)
   );

   typedef struct {
      logic [63:0] value;
      bit          exp_res;
      int          exp_reads;
      string       tag;
   } item_t;

   item_t q[$];
   int checks = 0, errors = 0, dones = 0, pushed = 0, reads = 0;
   logic [63:0] resp_data = '0;
   bit          resp_err = 1'b0;
   int          resp_lat = 0;
   bit          prev_done = 1'b0;
   bit          mon_on = 1'b0;

   task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // Memory responder.
   initial begin
      forever begin
         @(negedge clk);
         if (mem_rd_req) begin
            repeat (resp_lat) @(negedge clk);
            mem_rd_rsp_valid = 1'b1;
            mem_rd_rsp_data  = resp_data;
            mem_rd_rsp_err   = resp_err;
            @(negedge clk);
            mem_rd_rsp_valid = 1'b0;
            mem_rd_rsp_data  = '0;
            mem_rd_rsp_err   = 1'b0;
         end
      end
   end

   // Monitor / scoreboard.
   initial begin
      forever begin
         @(negedge clk);
         if (mon_on) begin
            if (mem_rd_req) begin
               reads++;
               if (q.size() > 0)
                  check(mem_rd_addr == q[0].value + 64'd24, "R4 read address",
                        mem_rd_addr, q[0].value + 64'd24);
            end
            if (done && prev_done) check(1'b0, "R8 done wider than one cycle", 1, 0);
            if (done) begin
               dones++;
               if (q.size() == 0) begin
                  check(1'b0, "R9 unexpected done", 1, 0);
               end else begin
                  item_t it;
                  it = q.pop_front();
                  check(is_obj == it.exp_res, it.tag, is_obj, it.exp_res);
                  check(reads == it.exp_reads, {it.tag, " read count"}, reads, it.exp_reads);
               end
               reads = 0;
            end
            prev_done = done;
         end
      end
   end

   task automatic send(logic [63:0] v, logic [63:0] d, bit e, int lat,
                       bit exp, int nrd, string tag);
      item_t it;
      while (!req_ready) @(negedge clk);
      resp_data = d; resp_err = e; resp_lat = lat;
      it.value = v; it.exp_res = exp; it.exp_reads = nrd; it.tag = tag;
      q.push_back(it);
      pushed++;
      req_valid = 1'b1; req_value = v;
      @(negedge clk);
      req_valid = 1'b0; req_value = '0;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(done == 1'b0, "R1 done after reset", done, 0);
      check(mem_rd_req == 1'b0, "R1 mem_rd_req after reset", mem_rd_req, 0);
      check(req_ready == 1'b1, "R1 req_ready after reset", req_ready, 1);
      mon_on = 1'b1;

      send(64'h1000,   MAGIC, 0, 2, 1, 1, "R5 object found");
      send(64'h0,      MAGIC, 0, 1, 1, 1, "R5 object at zero");
      send(64'h7FFFE0, MAGIC, 0, 0, 1, 1, "R3 top of range passes, R10 zero latency");
      send(64'h800000, MAGIC, 0, 0, 0, 0, "R3 bit 23 set");
      send(64'h8000000000000000, MAGIC, 0, 0, 0, 0, "R3 bit 63 set");
      send(64'h1001,   MAGIC, 0, 0, 0, 0, "R2 bit 0 set");
      send(64'h1010,   MAGIC, 0, 0, 0, 0, "R2 bit 4 set");
      send(64'h2000,   MAGIC | (64'h1 << 32), 0, 1, 0, 1, "R6 high bit differs");
      send(64'h2000,   64'h4F424B, 0, 1, 0, 1, "R6 low bit differs");
      send(64'h3000,   MAGIC, 1, 2, 0, 1, "R7 error response");
      send(64'h4000,   MAGIC, 0, 9, 1, 1, "R10 long latency");

      // R9: strobe a request while a read is outstanding.
      begin
         item_t it;
         while (!req_ready) @(negedge clk);
         resp_data = MAGIC; resp_err = 1'b0; resp_lat = 12;
         it.value = 64'h5000; it.exp_res = 1; it.exp_reads = 1;
         it.tag = "R9 busy request ignored";
         q.push_back(it);
         pushed++;
         req_valid = 1'b1; req_value = 64'h5000;
         @(negedge clk);
         req_valid = 1'b0;
         repeat (3) @(negedge clk);
         check(req_ready == 1'b0, "R9 busy during read", req_ready, 0);
         req_valid = 1'b1; req_value = 64'h6000;
         repeat (2) @(negedge clk);
         req_valid = 1'b0; req_value = '0;
         @(negedge clk);
         while (!req_ready) @(negedge clk);
         repeat (4) @(negedge clk);
      end

      check(dones == pushed, "R9 done count", dones, pushed);
      check(q.size() == 0, "R8 all requests completed", q.size(), 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule